// File: doc/BRIEF.md
# Sync-Triggered Capture Buffer

This block records a stretch of a single data stream into an on-chip memory of 1024 words, 32 bits each. Software arms it with a register write. The first sync beat that follows then opens a capture window. The window can be pushed back by a programmable number of valid beats. After that, every valid beat is stored at the next address until the memory is full.

A small register port returns three status counters: a sync count, a written-word count and a count of valid beats since the last sync. The same port also returns the delay setting and a fixed version number. A second read port fetches stored words by word address. Reading the last word of the memory clears the sync count, so software can tell how many syncs passed between two dumps. The block works on one stream in one clock domain.

Top module: `sync_capture_buffer`

## Requirements
- R1: After reset, register reads return 0 for the sync count, the word count, the valid count and the delay, and return VERSION at word address 7.
- R2: A write to register word address 2 (any data) arms the block. A beat with both `st_valid` and `st_sync` high is a sync beat. The first sync beat after arming starts a capture. While the block is not armed, sync beats store nothing.
- R3: Register word address 3 holds the delay D. It is written and read back as a 32-bit value. Number the valid beats from the arming sync beat, with the sync beat itself at position 0. The first stored word is the beat at position D. Beats before it are not stored.
- R4: Only beats with `st_valid` high are stored, at consecutive addresses starting from 0. Capture ends after 1024 words, and later beats do not change the memory. Sync beats that arrive during a capture do not restart it.
- R5: The word count is read at register word address 1. It equals the number of words stored by the current capture. It clears to 0 at the sync beat that starts a capture.
- R6: The sync count is read at register word address 0. It counts sync beats whether or not the block is armed. A buffer read of address 1023 clears it. Buffer reads of other addresses leave it unchanged.
- R7: A register read at word address 2 returns the number of valid beats since the last sync beat. That number is 0 right after the sync beat itself.
- R8: Register word address 7 returns VERSION. Word addresses 4, 5 and 6 read as 0.
- R9: Register read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high. Buffer read data appears on `buf_rdata` in the cycle after `buf_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_data | input | 32 | Stream data word |
| st_valid | input | 1 | Stream beat valid |
| st_sync | input | 1 | Sync marker, meaningful together with st_valid |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| buf_rd | input | 1 | Buffer read strobe |
| buf_addr | input | 10 | Buffer word address |
| buf_rdata | output | 32 | Buffer read data, one cycle after buf_rd |

## Verification
Each result has a fixed latency. Both read ports return data one cycle after the strobe is sampled. A stream beat changes the counters and the memory at the edge where it is sampled. The bench drives every input on the falling edge. Each read task pushes its expected value into a queue before its strobe reaches a rising edge. A monitor pops that value one time unit after the edge that loads the output register. Status is read only after the stream has gone idle, so each expected count follows from the beats driven and from the delay-position rule.

// File: rtl/sync_capture_buffer.sv
module sync_capture_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH = 1024,
  parameter int REG_W = 32,
  parameter logic [31:0] VERSION = 32'h0000_0001
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         st_data,
  input  logic                      st_valid,
  input  logic                      st_sync,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [2:0]                reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  input  logic                      buf_rd,
  input  logic [$clog2(DEPTH)-1:0]  buf_addr,
  output logic [DATA_W-1:0]         buf_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int WC_W = AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_DELAY, S_CAPT} st_t;

  st_t               st;
  logic [REG_W-1:0]  dly_reg, dly_cnt, sync_cnt, valid_cnt;
  logic [WC_W-1:0]   word_cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  logic sync_beat, arm_wr, start, wr_en, last_wr, sync_clr, is_idle;
  logic [AW-1:0] wr_addr;

  assign sync_beat = st_valid & st_sync;
  assign arm_wr    = reg_wr && reg_addr == 3'd2;
  assign start     = st == S_ARMED && sync_beat;
  assign wr_en     = st_valid && (st == S_CAPT ||
                     (st == S_DELAY && dly_cnt == '0) ||
                     (start && dly_reg == '0));
  assign wr_addr   = (st == S_ARMED) ? '0 : word_cnt[AW-1:0];
  assign last_wr   = wr_en && wr_addr == AW'(DEPTH-1);
  assign sync_clr  = buf_rd && buf_addr == AW'(DEPTH-1);
  assign is_idle   = st == S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dly_cnt  <= '0;
      word_cnt <= '0;
    end else begin
      if (start) word_cnt <= wr_en ? WC_W'(1) : '0;
      else if (wr_en) word_cnt <= word_cnt + 1'b1;

      if (arm_wr) st <= S_ARMED;
      else begin
        case (st)
          S_ARMED: if (sync_beat) begin
            if (dly_reg == '0) st <= last_wr ? S_IDLE : S_CAPT;
            else begin
              st      <= S_DELAY;
              dly_cnt <= dly_reg - 1'b1;
            end
          end
          S_DELAY: if (st_valid) begin
            if (dly_cnt == '0) st <= last_wr ? S_IDLE : S_CAPT;
            else dly_cnt <= dly_cnt - 1'b1;
          end
          S_CAPT: if (last_wr) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_reg   <= '0;
      sync_cnt  <= '0;
      valid_cnt <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd3) dly_reg <= reg_wdata;
      sync_cnt <= (sync_clr ? '0 : sync_cnt) + REG_W'(sync_beat);
      if (sync_beat) valid_cnt <= '0;
      else if (st_valid) valid_cnt <= valid_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        3'd0:    reg_rdata <= sync_cnt;
        3'd1:    reg_rdata <= REG_W'(word_cnt);
        3'd2:    reg_rdata <= valid_cnt;
        3'd3:    reg_rdata <= dly_reg;
        3'd7:    reg_rdata <= REG_W'(VERSION);
        default: reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= st_data;
    if (buf_rd) buf_rdata <= mem[buf_addr];
  end
endmodule

// File: rtl/sync_capture_buffer_chk.sv
module sync_capture_buffer_chk #(
  parameter int DEPTH = 1024,
  parameter int REG_W = 32,
  parameter logic [31:0] VERSION = 32'h0000_0001
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     st_valid,
  input logic                     st_sync,
  input logic                     is_idle,
  input logic [$clog2(DEPTH):0]   word_cnt,
  input logic [REG_W-1:0]         sync_cnt,
  input logic [REG_W-1:0]         valid_cnt,
  input logic                     reg_rd,
  input logic [2:0]               reg_addr,
  input logic [REG_W-1:0]         reg_rdata,
  input logic                     buf_rd,
  input logic [$clog2(DEPTH)-1:0] buf_addr
);
  localparam int AW = $clog2(DEPTH);

  AST_WORD_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= (AW+1)'(DEPTH)); // R4
  AST_GROW_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt != $past(word_cnt) && word_cnt != '0) |-> $past(st_valid)); // R4
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> word_cnt == $past(word_cnt)); // R2
  AST_SYNC_CLEARED_BY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && buf_addr == AW'(DEPTH-1)) |=> sync_cnt <= 1); // R6
  AST_VALID_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_sync) |=> valid_cnt == '0); // R7
  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd7) |=> reg_rdata == REG_W'(VERSION)); // R8
endmodule

bind sync_capture_buffer sync_capture_buffer_chk #(
  .DEPTH(DEPTH), .REG_W(REG_W), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_sync(st_sync),
  .is_idle(is_idle), .word_cnt(word_cnt), .sync_cnt(sync_cnt),
  .valid_cnt(valid_cnt), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .buf_rd(buf_rd), .buf_addr(buf_addr)
);

// File: tb/sync_capture_buffer_tb.sv
module sync_capture_buffer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] st_data = '0;
  logic        st_valid = 1'b0, st_sync = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        buf_rd = 1'b0;
  logic [9:0]  buf_addr = '0;
  logic [31:0] buf_rdata;

  int checks = 0, failures = 0;
  logic [31:0] reg_exp_q[$], buf_exp_q[$];
  string       reg_tag_q[$], buf_tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_capture_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .st_data(st_data), .st_valid(st_valid),
    .st_sync(st_sync), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_rd(buf_rd),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata)
  );

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: results are due one time unit after the edge that samples the strobe (R9)
  initial forever begin
    @(posedge clk);
    if (reg_rd) begin
      #1;
      if (reg_exp_q.size() > 0) compare(reg_rdata, reg_exp_q.pop_front(), reg_tag_q.pop_front());
    end else if (buf_rd) begin
      #1;
      if (buf_exp_q.size() > 0) compare(buf_rdata, buf_exp_q.pop_front(), buf_tag_q.pop_front());
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    reg_exp_q.push_back(exp); reg_tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_buf(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); buf_rd = 1'b1; buf_addr = a;
    buf_exp_q.push_back(exp); buf_tag_q.push_back(tag);
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic burst(input int n, input logic [31:0] base, input int sync_pos, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); st_valid = 1'b1; st_data = base + 32'(i); st_sync = (i == 0 || i == sync_pos);
      if (gap) begin @(negedge clk); st_valid = 1'b0; st_sync = 1'b0; end
    end
    @(negedge clk); st_valid = 1'b0; st_sync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(3'd0, 32'd0, "R1 sync count");
    rd_reg(3'd1, 32'd0, "R1 word count");
    rd_reg(3'd2, 32'd0, "R1 valid count");
    rd_reg(3'd3, 32'd0, "R1 delay");
    rd_reg(3'd7, 32'd1, "R1 version");
    // R8 unmapped offset
    rd_reg(3'd4, 32'd0, "R8 unmapped");
    // R2 unarmed: sync and beats store nothing
    burst(6, 32'h0000_0010, -1, 1'b1);
    rd_reg(3'd1, 32'd0, "R2 unarmed word count");
    rd_reg(3'd0, 32'd1, "R6 unarmed sync counted");
    rd_reg(3'd2, 32'd5, "R7 valid since sync");
    // R3 delay 3, sync inside capture at position 5 (R4)
    wr_reg(3'd3, 32'd3);
    rd_reg(3'd3, 32'd3, "R3 delay readback");
    wr_reg(3'd2, 32'hDEAD_BEEF);
    burst(10, 32'h0000_0100, 5, 1'b1);
    rd_reg(3'd1, 32'd7, "R5 word count after delay 3");
    rd_reg(3'd2, 32'd4, "R7 valid after mid sync");
    rd_buf(10'd0, 32'h0000_0103, "R3 first stored word");
    rd_buf(10'd2, 32'h0000_0105, "R4 mid sync no restart");
    rd_buf(10'd6, 32'h0000_0109, "R4 last stored word");
    rd_reg(3'd0, 32'd3, "R6 sync count");
    // R4 fill and stop at 1024, delay 0
    wr_reg(3'd3, 32'd0);
    wr_reg(3'd2, 32'd0);
    burst(1030, 32'h5000_0000, -1, 1'b0);
    rd_reg(3'd1, 32'd1024, "R4 full word count");
    rd_reg(3'd2, 32'd1029, "R7 valid after fill");
    rd_reg(3'd0, 32'd4, "R6 sync count before dump");
    rd_buf(10'd0, 32'h5000_0000, "R3 delay 0 stores sync beat");
    rd_reg(3'd0, 32'd4, "R6 not cleared by addr 0");
    rd_buf(10'd1023, 32'h5000_03FF, "R4 last slot kept");
    rd_reg(3'd0, 32'd0, "R6 cleared by last word read");
    // R5 rewrite clears word count, R3 delay 2 position
    wr_reg(3'd3, 32'd2);
    wr_reg(3'd2, 32'd0);
    burst(1, 32'h0000_7000, -1, 1'b0);
    rd_reg(3'd1, 32'd0, "R5 cleared at armed sync");
    @(negedge clk); st_valid = 1'b1; st_sync = 1'b0; st_data = 32'h7001;
    @(negedge clk); st_valid = 1'b0;
    rd_reg(3'd1, 32'd0, "R3 position 1 skipped");
    @(negedge clk); st_valid = 1'b1; st_data = 32'h7002;
    @(negedge clk); st_valid = 1'b0;
    rd_reg(3'd1, 32'd1, "R3 position 2 stored");
    rd_buf(10'd0, 32'h0000_7002, "R3 delay 2 word");
    rd_reg(3'd7, 32'd1, "R8 version");
    repeat (4) @(negedge clk);
    if (reg_exp_q.size() != 0 || buf_exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9 results missing actual=%0d expected=0", reg_exp_q.size() + buf_exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule